// File: doc/BRIEF.md
# Function-Select ALU with Status Flags

This block is a purely combinational function unit for a small register-transfer datapath. It takes two operands and a five-bit function code. It returns one result word and four status bits: negative, zero, carry and overflow. The control unit of the surrounding machine latches these status bits when it needs them. The function code selects one of three groups:

- an adder group for transfer, increment, add, subtract and decrement;
- a bitwise group for OR, AND, XOR, NOT and a pass-through of the second operand;
- a one-position shifter that acts only on the second operand.

Subtraction is not a separate circuit. The adder computes it as the first operand, plus the inverted second operand, plus a carry-in of one. Carry and overflow are meaningful only for the adder group and read zero for every other code. A code that names no operation yields a zero result, and the flags describe that zero.

Top module: `fsel_alu`

## Requirements
- R1: Code 00000 returns `a_i`, code 00001 returns `a_i`+1, and code 00110 returns `a_i`−1, all modulo 2^W.
- R2: Code 00010 returns `a_i`+`b_i`. Code 00101 returns `a_i`−`b_i`, formed as `a_i` + ~`b_i` + 1.
- R3: For the adder codes, `c_o` is the carry out of the top bit. Decrement reports the carry of `a_i` + all-ones, and subtract reports 1 when no borrow occurs.
- R4: For the adder codes, `v_o` is 1 exactly when the signed two's-complement result does not fit in W bits.
- R5: Codes 0100x give OR, 0101x give AND, 0110x give XOR and 0111x give ~`a_i`. The lowest code bit has no effect on these codes.
- R6: Codes 100xx return `b_i` unchanged, whatever the two low code bits are.
- R7: Codes 110xx shift `b_i` left by one and fill with 0. Codes 1010x shift `b_i` right by one and fill with 0. Codes 1011x shift `b_i` right by one and copy the sign bit, so 0x80FF0001 becomes 0xC07F8000.
- R8: For every code, `n_o` equals the result's top bit and `z_o` is 1 exactly when the result is all zeros.
- R9: For every code whose bit 4 or bit 3 is set, `c_o` and `v_o` are 0, even when a shift moves a 1 out of the word.
- R10: Codes 00011, 00100, 00111 and 111xx return 0, with `z_o`=1 and `n_o`=`c_o`=`v_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand (adder and bitwise groups) |
| b_i | input | W | Second operand (adder, bitwise and shifter groups) |
| fs_i | input | 5 | Function code |
| f_o | output | W | Result word |
| n_o | output | 1 | Result is negative (top bit) |
| z_o | output | 1 | Result is all zeros |
| c_o | output | 1 | Adder carry out |
| v_o | output | 1 | Adder signed overflow |

## Verification
The bench builds the unit at the default width W=32. At that width the documented arithmetic-shift value 0x80FF0001 is representable. The 32-bit sign and carry boundaries can also be driven: 0x7FFFFFFF, 0x80000000 and all-ones. Those values reach the increment wrap, decrement of zero, both signs of add and subtract overflow, and shifts that push a 1 out of either end. A final sweep applies all 32 function codes with all-ones operands. It confirms the flag rules on every code, including the reserved ones and the ignored low code bits.

// File: rtl/fsel_alu_pkg.sv
`timescale 1ns/1ps
package fsel_alu_pkg;

    localparam int FS_W = 5;

    typedef enum logic [3:0] {
        OP_ZERO, OP_PASSA, OP_INC, OP_ADD, OP_SUB, OP_DEC,
        OP_OR, OP_AND, OP_XOR, OP_NOTA, OP_PASSB,
        OP_LSR, OP_ASR, OP_LSL
    } op_e;

    typedef enum logic [1:0] {
        GRP_NONE, GRP_ARITH, GRP_BITWISE, GRP_SHIFT
    } grp_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic op_e decode_fs(input logic [FS_W-1:0] fs);
        op_e op;
        casez (fs)
            5'b00000: op = OP_PASSA;
            5'b00001: op = OP_INC;
            5'b00010: op = OP_ADD;
            5'b00101: op = OP_SUB;
            5'b00110: op = OP_DEC;
            5'b0100?: op = OP_OR;
            5'b0101?: op = OP_AND;
            5'b0110?: op = OP_XOR;
            5'b0111?: op = OP_NOTA;
            5'b100??: op = OP_PASSB;
            5'b1010?: op = OP_LSR;
            5'b1011?: op = OP_ASR;
            5'b110??: op = OP_LSL;
            default:  op = OP_ZERO;
        endcase
        return op;
    endfunction

    function automatic grp_e group_of(input op_e op);
        grp_e g;
        case (op)
            OP_PASSA, OP_INC, OP_ADD, OP_SUB, OP_DEC: g = GRP_ARITH;
            OP_OR, OP_AND, OP_XOR, OP_NOTA, OP_PASSB: g = GRP_BITWISE;
            OP_LSR, OP_ASR, OP_LSL:                   g = GRP_SHIFT;
            default:                                  g = GRP_NONE;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/fsel_alu_arith.sv
`timescale 1ns/1ps
module fsel_alu_arith
    import fsel_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] opb;
    logic         cin;
    logic [W:0]   wide;

    always_comb begin
        case (op)
            OP_INC:  begin opb = '0; cin = 1'b1; end
            OP_ADD:  begin opb = b;  cin = 1'b0; end
            OP_SUB:  begin opb = ~b; cin = 1'b1; end
            OP_DEC:  begin opb = '1; cin = 1'b0; end
            default: begin opb = '0; cin = 1'b0; end
        endcase
    end

    assign wide = {1'b0, a} + {1'b0, opb} + {{W{1'b0}}, cin};
    assign sum  = wide[W-1:0];
    assign cout = wide[W];
    assign ovf  = (a[W-1] == opb[W-1]) && (sum[W-1] != a[W-1]);

endmodule

// File: rtl/fsel_alu_bitwise.sv
`timescale 1ns/1ps
module fsel_alu_bitwise
    import fsel_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            OP_OR:    y = a | b;
            OP_AND:   y = a & b;
            OP_XOR:   y = a ^ b;
            OP_NOTA:  y = ~a;
            OP_PASSB: y = b;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/fsel_alu_shift.sv
`timescale 1ns/1ps
module fsel_alu_shift
    import fsel_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W-1:0] y
);
    logic [W-1:0] left, rlog, rari;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lo
            assign left[i] = 1'b0;
        end else begin : g_lo
            assign left[i] = b[i-1];
        end
        if (i == W-1) begin : g_hi
            assign rlog[i] = 1'b0;
            assign rari[i] = b[W-1];
        end else begin : g_hi
            assign rlog[i] = b[i+1];
            assign rari[i] = b[i+1];
        end
    end

    always_comb begin
        case (op)
            OP_LSL:  y = left;
            OP_LSR:  y = rlog;
            OP_ASR:  y = rari;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/fsel_alu.sv
`timescale 1ns/1ps
module fsel_alu
    import fsel_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [FS_W-1:0] fs_i,
    output logic [W-1:0]    f_o,
    output logic            n_o,
    output logic            z_o,
    output logic            c_o,
    output logic            v_o
);
    op_e          op;
    grp_e         grp;
    logic [W-1:0] arith_y, bit_y, shift_y;
    logic         arith_c, arith_v;
    flags_t       flg;

    assign op  = decode_fs(fs_i);
    assign grp = group_of(op);

    fsel_alu_arith #(.W(W)) u_arith (
        .a(a_i), .b(b_i), .op(op), .sum(arith_y), .cout(arith_c), .ovf(arith_v)
    );

    fsel_alu_bitwise #(.W(W)) u_bitwise (
        .a(a_i), .b(b_i), .op(op), .y(bit_y)
    );

    fsel_alu_shift #(.W(W)) u_shift (
        .b(b_i), .op(op), .y(shift_y)
    );

    always_comb begin
        case (grp)
            GRP_ARITH:   f_o = arith_y;
            GRP_BITWISE: f_o = bit_y;
            GRP_SHIFT:   f_o = shift_y;
            default:     f_o = '0;
        endcase
        flg.n = f_o[W-1];
        flg.z = (f_o == '0);
        flg.c = (grp == GRP_ARITH) ? arith_c : 1'b0;
        flg.v = (grp == GRP_ARITH) ? arith_v : 1'b0;
    end

    assign n_o = flg.n;
    assign z_o = flg.z;
    assign c_o = flg.c;
    assign v_o = flg.v;

endmodule

// File: rtl/fsel_alu_chk.sv
`timescale 1ns/1ps
module fsel_alu_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [4:0]   fs_i,
    input logic [W-1:0] f_o,
    input logic         n_o,
    input logic         z_o,
    input logic         c_o,
    input logic         v_o
);
    logic [W:0] add_ref;
    logic       undef_code;

    assign add_ref    = {1'b0, a_i} + {1'b0, b_i};
    assign undef_code = (fs_i == 5'b00011) || (fs_i == 5'b00100) ||
                        (fs_i == 5'b00111) || (fs_i[4:2] == 3'b111);

    always_comb begin
        AST_N_IS_MSB: assert (n_o == f_o[W-1]) else $error("n flag mismatch"); // R8
        AST_Z_IS_ZERO: assert (z_o == (f_o == '0)) else $error("z flag mismatch"); // R8
        if (fs_i[4] || fs_i[3]) begin
            AST_NONARITH_CV_CLEAR: assert (!c_o && !v_o) else $error("c/v set on non-adder code"); // R9
        end
        if (fs_i[4:2] == 3'b100) begin
            AST_PASSB_COPIES: assert (f_o == b_i) else $error("pass-b mismatch"); // R6
        end
        if (undef_code) begin
            AST_UNDEF_ZERO: assert (f_o == '0 && !c_o && !v_o) else $error("reserved code not zero"); // R10
        end
        if (fs_i == 5'b00010) begin
            AST_ADD_CARRY_SUM: assert ({c_o, f_o} == add_ref) else $error("add mismatch"); // R3
        end
        if (fs_i == 5'b00101) begin
            AST_SUB_DIFF: assert (f_o == a_i - b_i) else $error("sub mismatch"); // R2
        end
        if (fs_i == 5'b00000) begin
            AST_PASSA_QUIET: assert (f_o == a_i && !c_o && !v_o) else $error("pass-a mismatch"); // R1
        end
    end
endmodule

bind fsel_alu fsel_alu_chk #(.W(W)) i_chk (
    .a_i(a_i), .b_i(b_i), .fs_i(fs_i), .f_o(f_o),
    .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o)
);

// File: tb/test_fsel_alu.sv
`timescale 1ns/1ps
module test_fsel_alu;
    localparam int W = 32;
    localparam int NV = 36;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b, f;
    logic [4:0]   fs;
    logic         n, z, c, v;
    int           checks = 0;
    int           errors = 0;
    bit           done = 0;

    always #2.5 clk = ~clk;

    fsel_alu #(.W(W)) i_fsel_alu (
        .a_i(a), .b_i(b), .fs_i(fs), .f_o(f),
        .n_o(n), .z_o(z), .c_o(c), .v_o(v)
    );

    // {fs, a, b, expected result, expected {n,z,c,v}}
    localparam logic [104:0] VECS [NV] = '{
        {5'b00000, 32'h12345678, 32'hFFFFFFFF, 32'h12345678, 4'b0000}, // R1 pass a
        {5'b00001, 32'h000000FF, 32'h0,        32'h00000100, 4'b0000}, // R1 inc
        {5'b00001, 32'hFFFFFFFF, 32'h0,        32'h00000000, 4'b0110}, // R3 inc wrap
        {5'b00001, 32'h7FFFFFFF, 32'h0,        32'h80000000, 4'b1001}, // R4 inc ovf
        {5'b00010, 32'h00000001, 32'h00000002, 32'h00000003, 4'b0000}, // R2 add
        {5'b00010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0110}, // R3 add carry
        {5'b00010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b1001}, // R4 add ovf
        {5'b00010, 32'h80000000, 32'h80000000, 32'h00000000, 4'b0111}, // R4 neg ovf
        {5'b00101, 32'h00000005, 32'h00000003, 32'h00000002, 4'b0010}, // R2 sub
        {5'b00101, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 4'b1000}, // R3 sub borrow
        {5'b00101, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 4'b0011}, // R4 sub ovf
        {5'b00101, 32'hDEADBEEF, 32'hDEADBEEF, 32'h00000000, 4'b0110}, // R2 sub equal
        {5'b00110, 32'h00000001, 32'h0,        32'h00000000, 4'b0110}, // R3 dec carry
        {5'b00110, 32'h00000000, 32'h0,        32'hFFFFFFFF, 4'b1000}, // R1 dec zero
        {5'b00110, 32'h80000000, 32'h0,        32'h7FFFFFFF, 4'b0011}, // R4 dec ovf
        {5'b01000, 32'hF0F00000, 32'h00000F0F, 32'hF0F00F0F, 4'b1000}, // R5 or
        {5'b01001, 32'hF0F00000, 32'h00000F0F, 32'hF0F00F0F, 4'b1000}, // R5 or low bit
        {5'b01010, 32'hFF00FF00, 32'h0F0F0F0F, 32'h0F000F00, 4'b0000}, // R5 and
        {5'b01011, 32'hAAAAAAAA, 32'h55555555, 32'h00000000, 4'b0100}, // R5 and zero
        {5'b01100, 32'hFFFF0000, 32'h0F0F0F0F, 32'hF0F00F0F, 4'b1000}, // R5 xor
        {5'b01101, 32'h12345678, 32'h12345678, 32'h00000000, 4'b0100}, // R5 xor self
        {5'b01110, 32'h00000000, 32'h12345678, 32'hFFFFFFFF, 4'b1000}, // R5 not
        {5'b01111, 32'hFFFFFFFF, 32'h0,        32'h00000000, 4'b0100}, // R5 not low bit
        {5'b10000, 32'hFFFFFFFF, 32'h80000001, 32'h80000001, 4'b1000}, // R6 pass b
        {5'b10011, 32'h00000001, 32'h00000000, 32'h00000000, 4'b0100}, // R6 pass b zero
        {5'b10100, 32'h0,        32'h80000001, 32'h40000000, 4'b0000}, // R7 lsr
        {5'b10101, 32'h0,        32'h00000001, 32'h00000000, 4'b0100}, // R9 lsr out
        {5'b10110, 32'h0,        32'h80FF0001, 32'hC07F8000, 4'b1000}, // R7 asr
        {5'b10111, 32'h0,        32'h7FFFFFFE, 32'h3FFFFFFF, 4'b0000}, // R7 asr pos
        {5'b11000, 32'h0,        32'h80000001, 32'h00000002, 4'b0000}, // R9 lsl out
        {5'b11011, 32'h0,        32'h40000000, 32'h80000000, 4'b1000}, // R7 lsl
        {5'b00011, 32'h00000001, 32'h00000002, 32'h00000000, 4'b0100}, // R10
        {5'b00100, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 4'b0100}, // R10
        {5'b00111, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0100}, // R10
        {5'b11100, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 4'b0100}, // R10
        {5'b11111, 32'h12345678, 32'h87654321, 32'h00000000, 4'b0100}  // R10
    };

    function automatic string req_of(input logic [4:0] code);
        casez (code)
            5'b00000, 5'b00001, 5'b00110: return "R1";
            5'b00010, 5'b00101:           return "R2";
            5'b00011, 5'b00100, 5'b00111: return "R10";
            5'b111??:                     return "R10";
            5'b01???:                     return "R5";
            5'b100??:                     return "R6";
            default:                      return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] f_exp, input logic [3:0] fl_exp);
        checks++;
        if (f !== f_exp || {n, z, c, v} !== fl_exp) begin
            errors++;
            $display("FAIL %s (flags R3 R4 R8 R9) fs=%b: f=%h nzcv=%b, expected f=%h nzcv=%b",
                     tag, fs, f, {n, z, c, v}, f_exp, fl_exp);
        end
    endtask

    task automatic apply(input logic [4:0] fs_v, input logic [W-1:0] a_v, input logic [W-1:0] b_v);
        @(posedge clk);
        fs = fs_v; a = a_v; b = b_v;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; fs = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: zero inputs, pass-a gives zero with Z set (R1, R8)
        check("R1 reset", 32'h0, 4'b0100);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][104:100], VECS[i][99:68], VECS[i][67:36]);
            check(req_of(VECS[i][104:100]), VECS[i][35:4], VECS[i][3:0]);
        end

        // sweep every code with all-ones operands: flag rules R8, R9
        for (int k = 0; k < 32; k++) begin
            apply(5'(k), 32'hFFFFFFFF, 32'hFFFFFFFF);
            checks++;
            if (n !== f[W-1] || z !== (f == '0)) begin
                errors++;
                $display("FAIL R8 fs=%b: nz=%b%b, expected %b%b", fs, n, z, f[W-1], (f == '0));
            end
            if (fs[4] || fs[3]) begin
                checks++;
                if (c !== 1'b0 || v !== 1'b0) begin
                    errors++;
                    $display("FAIL R9 fs=%b: cv=%b%b, expected 00", fs, c, v);
                end
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule